// File: doc/BRIEF.md
# Two-Level Page Walker with Large-Page Mapping

This block turns a 32-bit virtual address into a physical address of up to 36 bits by reading a two-level translation table from memory. It fetches one 32-bit entry from the first-level table (the directory), which the base register selects. That entry either maps a 4 MiB page and ends the walk, or points to a second-level table whose entry maps a 4 KiB page. Large-page mapping takes effect only while its enable input is set. A second enable lets a large-page entry supply four physical address bits above bit 31.

A client presents a request with a valid/ready handshake. The walker handles one request at a time. It captures the address, the base register and both enables when it accepts the request. It reads entries through a simple memory port: a request is held until it is granted, and the read data returns later with a valid strobe. The walk finishes with a one-cycle done pulse. The pulse carries the physical address, a large-page flag and a fault flag.

Top module: `page_walker`

## Requirements
- R1: The first read of every walk goes to address {base[31:12], va[31:22], 2'b00}, where base and va are the values captured when the request was accepted.
- R2: On a two-level walk the second read goes to {dir_entry[31:12], va[21:12], 2'b00}. The result is {4'b0, tbl_entry[31:12], va[11:0]} with large_o = 0.
- R3: While the large-page enable is 0, bit 7 of a directory entry has no effect: every walk with a present directory entry does two reads.
- R4: While the large-page enable is 1, a present directory entry with bit 7 = 1 ends the walk after exactly one read. The result is {hi, dir_entry[31:22], va[21:0]} with large_o = 1.
- R5: While the large-page enable is 1, a present directory entry with bit 7 = 0 is walked exactly as in R2.
- R6: For a large page, hi (pa_o[35:32]) equals dir_entry[16:13] when the 36-bit enable is 1, and 0 when it is 0. A small-page result always has pa_o[35:32] = 0.
- R7: Bit 0 of each entry is the present flag. If it is 0 at either level, the walk ends with fault_o = 1, pa_o = 0 and large_o = 0, and no further read is issued.
- R8: req_ready_o is high only while the walker is idle. done_o is a single-cycle pulse. A memory request stays asserted, with a stable address, until it is granted. Each walk issues at most two reads.
- R9: Changes on the request, base and enable inputs after a request is accepted do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr_i | input | 32 | Virtual address to translate |
| dir_base_i | input | 32 | Directory base register |
| large_en_i | input | 1 | Large-page mapping enable |
| ext36_en_i | input | 1 | 36-bit large-page address enable |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 32 | Entry byte address |
| mem_gnt_i | input | 1 | Read request granted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read entry |
| done_o | output | 1 | Walk complete, one cycle |
| pa_o | output | 36 | Physical address (zero on fault) |
| large_o | output | 1 | Result is a large page |
| fault_o | output | 1 | Not-present fault |

## Verification
The bench sets bit 7 in directory entries while large pages are disabled. A walker that looked at that bit there would stop after one read with a wrong address. Large pages are run with the 36-bit enable both on and off. A design that mixed up the high bits would show nonzero upper bits, or lose them. Not-present entries are placed at each level to catch a walk that continues past a fault or reports a partial address. The bench also changes every input right after acceptance, which exposes a design that reads live inputs instead of the captured ones. Random grant and response delays test whether the request is held correctly.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 36;
  localparam int ENT_W    = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int LG_OFF_W = OFF_W + IDX_W;
  localparam int FRAME_W  = VA_W - OFF_W;
  localparam int LG_FRM_W = VA_W - LG_OFF_W;
  localparam int HI_W     = PA_W - VA_W;
  localparam int PS_BIT   = 7;
  localparam int PRES_BIT = 0;
  localparam int HI_LSB   = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_DONE
  } walk_st_e;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
  import pw_pkg::*;
(
  input  logic             tbl_lvl_i,
  input  logic [VA_W-1:0]  base_i,
  input  logic [ENT_W-1:0] pde_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [VA_W-1:0]  addr_o
);
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    frame  = tbl_lvl_i ? pde_i[ENT_W-1 -: FRAME_W] : base_i[VA_W-1 -: FRAME_W];
    idx    = tbl_lvl_i ? va_i[OFF_W +: IDX_W] : va_i[LG_OFF_W +: IDX_W];
    addr_o = {frame, idx, 2'b00};
  end
endmodule

// File: rtl/pw_pa_build.sv
module pw_pa_build
  import pw_pkg::*;
(
  input  logic             large_i,
  input  logic             ext36_i,
  input  logic             fault_i,
  input  logic [ENT_W-1:0] pde_i,
  input  logic [ENT_W-1:0] pte_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [HI_W-1:0] hi;

  always_comb begin
    hi = ext36_i ? pde_i[HI_LSB +: HI_W] : '0;
    if (fault_i)
      pa_o = '0;
    else if (large_i)
      pa_o = {hi, pde_i[ENT_W-1 -: LG_FRM_W], va_i[LG_OFF_W-1:0]};
    else
      pa_o = {{HI_W{1'b0}}, pte_i[ENT_W-1 -: FRAME_W], va_i[OFF_W-1:0]};
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [VA_W-1:0]  dir_base_i,
  input  logic             large_en_i,
  input  logic             ext36_en_i,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             large_o,
  output logic             fault_o
);
  walk_st_e         state_q;
  logic [VA_W-1:0]  va_q, base_q;
  logic [ENT_W-1:0] pde_q, pte_q;
  logic             lg_en_q, x36_q, fault_q, large_q;
  logic [PA_W-1:0]  pa_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      pte_q   <= '0;
      lg_en_q <= 1'b0;
      x36_q   <= 1'b0;
      fault_q <= 1'b0;
      large_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          base_q  <= dir_base_i;
          lg_en_q <= large_en_i;
          x36_q   <= ext36_en_i;
          fault_q <= 1'b0;
          large_q <= 1'b0;
          state_q <= ST_DIR_REQ;
        end
        ST_DIR_REQ: if (mem_gnt_i) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rvalid_i) begin
          pde_q <= mem_rdata_i;
          if (!mem_rdata_i[PRES_BIT]) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (lg_en_q && mem_rdata_i[PS_BIT]) begin
            large_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_gnt_i) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rvalid_i) begin
          pte_q   <= mem_rdata_i;
          fault_q <= !mem_rdata_i[PRES_BIT];
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pw_addr_gen u_addr_gen (
    .tbl_lvl_i (state_q == ST_TBL_REQ),
    .base_i    (base_q),
    .pde_i     (pde_q),
    .va_i      (va_q),
    .addr_o    (mem_addr_o)
  );

  pw_pa_build u_pa_build (
    .large_i (large_q),
    .ext36_i (x36_q),
    .fault_i (fault_q),
    .pde_i   (pde_q),
    .pte_i   (pte_q),
    .va_i    (va_q),
    .pa_o    (pa_raw)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign done_o      = (state_q == ST_DONE);
  assign pa_o        = done_o ? pa_raw : '0;
  assign large_o     = done_o & large_q;
  assign fault_o     = done_o & fault_q;

  p_dir_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o &&
      mem_addr_o == {$past(dir_base_i[VA_W-1 -: FRAME_W]), $past(req_vaddr_i[LG_OFF_W +: IDX_W]), 2'b00});
  p_hi_zero_small_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !large_o |-> pa_o[PA_W-1 -: HI_W] == '0);
  p_fault_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> pa_o == '0 && !large_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));
  p_one_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(large_o && fault_o));
endmodule

// File: tb/page_walker_tb_top.sv
`timescale 1ns/1ps
module page_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] dir_base_i = '0;
  logic        large_en_i = 1'b0;
  logic        ext36_en_i = 1'b0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i = 1'b0;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [35:0] pa_o;
  logic        large_o;
  logic        fault_o;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic [31:0] rd_addr [2];
  int unsigned mem [int unsigned];

  always #4 clk = ~clk;

  page_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .dir_base_i(dir_base_i),
    .large_en_i(large_en_i), .ext36_en_i(ext36_en_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .pa_o(pa_o), .large_o(large_o), .fault_o(fault_o)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    logic [31:0] h;
    if (mem.exists(a)) return mem[a];
    h = a * 32'h9E3779B1;
    return h ^ {h[15:0], h[31:16]} ^ 32'h5BD1E995;
  endfunction

  function automatic logic [31:0] dir_addr(input logic [31:0] base, input logic [31:0] va);
    return {base[31:12], va[31:22], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rid, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rid, act, exp);
    end
  endtask

  // memory responder: random grant and latency
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_gnt_i = 1'b0;
      mem_rvalid_i = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i = rd(paddr);
          pend = 0;
        end else lat--;
      end else if (mem_req_o && rst_n) begin
        if ($urandom_range(0, 2) != 0) begin
          mem_gnt_i = 1'b1;
          paddr = mem_addr_o;
          pend = 1;
          lat = $urandom_range(0, 2);
          if (nreads < 2) rd_addr[nreads] = mem_addr_o;
          nreads++;
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit le, input bit x36);
    logic [31:0] pde, pte;
    logic [35:0] exp_pa;
    bit exp_lg, exp_ft;
    int exp_n;
    int cyc;
    pde = rd(dir_addr(base, va));
    pte = rd({pde[31:12], va[21:12], 2'b00});
    exp_lg = 0; exp_ft = 0; exp_pa = '0; exp_n = 1;
    if (!pde[0]) exp_ft = 1;
    else if (le && pde[7]) begin
      exp_lg = 1;
      exp_pa = {x36 ? pde[16:13] : 4'h0, pde[31:22], va[21:0]};
    end else begin
      exp_n = 2;
      if (!pte[0]) exp_ft = 1;
      else exp_pa = {4'h0, pte[31:12], va[11:0]};
    end
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R8 ready when idle", 64'(req_ready_o), 64'd1);
    nreads = 0;
    req_valid_i = 1'b1; req_vaddr_i = va; dir_base_i = base;
    large_en_i = le; ext36_en_i = x36;
    @(negedge clk);
    req_valid_i = 1'b0;
    // R9: scramble inputs during the walk
    req_vaddr_i = $urandom; dir_base_i = $urandom;
    large_en_i = ~le; ext36_en_i = ~x36;
    chk(req_ready_o == 1'b0, "R8 busy after accept", 64'(req_ready_o), 64'd0);
    cyc = 0;
    while (!done_o && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    chk(done_o == 1'b1, "R8 walk completes", 64'(done_o), 64'd1);
    chk(pa_o == exp_pa, "R2/R4/R6/R9 physical address", 64'(pa_o), 64'(exp_pa));
    chk(large_o == exp_lg, "R3/R4/R5 large flag", 64'(large_o), 64'(exp_lg));
    chk(fault_o == exp_ft, "R7 fault flag", 64'(fault_o), 64'(exp_ft));
    chk(nreads == exp_n, "R3/R4/R7 read count", 64'(nreads), 64'(exp_n));
    chk(rd_addr[0] == dir_addr(va === va ? base : base, va), "R1 directory address",
        64'(rd_addr[0]), 64'(dir_addr(base, va)));
    if (exp_n == 2)
      chk(rd_addr[1] == {pde[31:12], va[21:12], 2'b00}, "R2 table address",
          64'(rd_addr[1]), 64'({pde[31:12], va[21:12], 2'b00}));
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done single cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] va, base, da;
    va = 32'h0AB5_6789;
    base = 32'h0012_3ABC;
    da = dir_addr(base, va);
    repeat (3) @(negedge clk);
    chk(req_ready_o == 1'b1 && mem_req_o == 1'b0 && done_o == 1'b0, "R8 reset state",
        64'({req_ready_o, mem_req_o, done_o}), 64'b100);
    rst_n = 1'b1;

    // R2 small page, large disabled
    mem[da] = 32'h0456_7001;
    mem[{20'h04567, va[21:12], 2'b00}] = 32'h89AB_C003;
    walk(va, base, 0, 1);
    // R3 bit 7 ignored while large disabled
    mem[da] = 32'h0456_7081;
    walk(va, base, 0, 1);
    // R4 R6 large page with high bits
    mem[da] = 32'hC041_E081;
    walk(va, base, 1, 1);
    walk(va, base, 1, 0);
    // R5 enabled, bit 7 clear
    mem[da] = 32'h0456_7001;
    walk(va, base, 1, 1);
    // R7 directory not present, bit 7 set
    mem[da] = 32'hFFFF_FF80;
    walk(va, base, 1, 1);
    // R7 table entry not present
    mem[da] = 32'h0456_7001;
    mem[{20'h04567, va[21:12], 2'b00}] = 32'h89AB_C002;
    walk(va, base, 0, 0);

    void'($urandom(32'd1234));
    mem.delete();
    for (int i = 0; i < 400; i++)
      walk($urandom, $urandom, 1'($urandom), 1'($urandom));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule